// File: doc/BRIEF.md
# Parity Transceiver with Error Flag

This block sits between two 8-bit buses, called the A side and the B side, together with a ninth line that carries odd parity. Two active-low direction enables choose among four modes. In the first, A drives B and the block generates parity. In the second, B drives A and the block checks the nine incoming bits. In the third, a diagnostic mode, A drives B while the parity line carries deliberately wrong parity. In the fourth, every driver is released. Each three-state pad appears as separate input, output and output-enable signals, so a pad ring or an on-chip bus mux can resolve it.

A parity failure feeds a one-bit error flag. Two active-low controls, a flag enable and a flag clear, set the flag's mode. It can pass the check straight through, capture failures until cleared, hold its value, or return to the no-error state. The flag leaves the block as an open-drain style pull-low request: asserting the request means an error, and releasing it lets the shared wire float high.

Top module: `parity_xcvr`

## Requirements
- R1: With `oe_a_n`=1 and `oe_b_n`=0, `b_out` equals `a_in`, `b_oe`=1, `a_oe`=0 and `par_oe`=1. `par_out` makes the total count of ones in `a_in` plus `par_out` odd.
- R2: With `oe_a_n`=0 and `oe_b_n`=1, `a_out` equals `b_in`, `a_oe`=1, `b_oe`=0 and `par_oe`=0.
- R3: With both enables at 0, `b_out` equals `a_in` and `b_oe`=1, while `a_oe`=0. `par_out` is driven (`par_oe`=1) with the inverse of the R1 parity, so `a_in` plus `par_out` has an even count of ones.
- R4: With both enables at 1, `a_oe`, `b_oe` and `par_oe` are all 0.
- R5: In pass mode (`flag_en_n`=0, `flag_clr_n`=0) in the B-to-A mode, `err_pull_low` is 1 in the same cycle when `b_in` plus `par_in` has an even count of ones, and 0 when the count is odd. The last pass value is still held after the controls move to store mode.
- R6: In sample mode (`flag_en_n`=0, `flag_clr_n`=1), a failing check asserts `err_pull_low` in the same cycle. Once the flag is asserted, it stays asserted over later clock edges even when the data passes.
- R7: In clear mode (`flag_en_n`=1, `flag_clr_n`=0), `err_pull_low` is 0. After a clock edge in this mode, the flag stays released when the controls move to store mode.
- R8: In store mode (`flag_en_n`=1, `flag_clr_n`=1), `err_pull_low` keeps its value over clock edges, whatever the data on either side.
- R9: In the diagnostic mode, the check runs on `a_in` alone. In pass mode, `err_pull_low` is 1 when `a_in` has an even count of ones and 0 when the count is odd.
- R10: In the A-to-B and released modes no check runs. In pass mode, `err_pull_low` is 0 for every data value.
- R11: After `rst_n` is deasserted, the flag is in the no-error state: in store mode, `err_pull_low` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the error flag register |
| rst_n | input | 1 | Asynchronous active-low reset; sets the flag to no-error |
| oe_a_n | input | 1 | Active-low enable of the A-side drivers |
| oe_b_n | input | 1 | Active-low enable of the B-side and parity drivers |
| flag_en_n | input | 1 | Active-low flag enable |
| flag_clr_n | input | 1 | Active-low flag clear |
| a_in | input | 8 | Value seen on the A pads |
| a_out | output | 8 | Value to drive on the A pads |
| a_oe | output | 1 | Drive enable for the A pads |
| b_in | input | 8 | Value seen on the B pads |
| b_out | output | 8 | Value to drive on the B pads |
| b_oe | output | 1 | Drive enable for the B pads |
| par_in | input | 1 | Value seen on the parity pad |
| par_out | output | 1 | Value to drive on the parity pad |
| par_oe | output | 1 | Drive enable for the parity pad |
| err_pull_low | output | 1 | 1 pulls the shared error wire low (error); 0 releases it |

## Verification
The bench sweeps every A value through the generate and diagnostic modes, and every B value with both parity-input levels through the check mode. A design that swaps the parity sense or forgets the diagnostic inversion therefore fails on half of the patterns. The flag sequences go after the ordering corners. One is a passing word arriving after a capture in sample mode: a design without stickiness would release the flag here. Another is a store phase fed with failing data: a design that keeps sampling would set the flag. A third is a clear followed by store, and a fourth is a pass-mode value that must survive into store. The bench also confirms that the generate and released modes never raise the flag, a case where a design that checks stale B data would report spurious errors.

// File: rtl/ptx_pkg.sv
package ptx_pkg;

    // Direction selected by the two active-low pad enables
    typedef enum logic [1:0] {
        DIR_OFF  = 2'b00,
        DIR_A2B  = 2'b01,
        DIR_B2A  = 2'b10,
        DIR_DIAG = 2'b11
    } dir_e;

    // Flag mode, encoded as {~flag_en_n, ~flag_clr_n}
    typedef enum logic [1:0] {
        FLG_STORE  = 2'b00,
        FLG_CLEAR  = 2'b01,
        FLG_SAMPLE = 2'b10,
        FLG_PASS   = 2'b11
    } flg_e;

    // Registered state of the flag block; flag = 1 means no error
    typedef struct packed {
        logic flag;
    } flag_st_t;

endpackage

// File: rtl/ptx_dir_ctrl.sv
module ptx_dir_ctrl
    import ptx_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             oe_a_n,
    input  logic             oe_b_n,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    output dir_e             dir,
    output logic [WIDTH-1:0] a_out,
    output logic             a_oe,
    output logic [WIDTH-1:0] b_out,
    output logic             b_oe
);

    always_comb begin
        unique case ({oe_a_n, oe_b_n})
            2'b10:   dir = DIR_A2B;
            2'b01:   dir = DIR_B2A;
            2'b00:   dir = DIR_DIAG;
            default: dir = DIR_OFF;
        endcase
    end

    // The A side drives only when B is the source; in diagnostic mode A stays an input
    assign a_oe = (dir == DIR_B2A);
    assign b_oe = (dir == DIR_A2B) || (dir == DIR_DIAG);

    // Gate each lane so undriven pads present a quiet zero toward the pad ring
    for (genvar i = 0; i < WIDTH; i++) begin : g_lane
        assign a_out[i] = a_oe & b_in[i];
        assign b_out[i] = b_oe & a_in[i];
    end

endmodule

// File: rtl/ptx_parity.sv
module ptx_parity
    import ptx_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  dir_e             dir,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic             par_in,
    output logic             par_out,
    output logic             par_oe,
    output logic             chk_ok
);

    logic a_xor;
    logic b_xor;

    assign a_xor = ^a_in;
    assign b_xor = ^{b_in, par_in};

    always_comb begin
        par_out = 1'b0;
        par_oe  = 1'b0;
        chk_ok  = 1'b1;
        unique case (dir)
            DIR_A2B: begin
                par_oe  = 1'b1;
                par_out = ~a_xor;
            end
            DIR_DIAG: begin
                par_oe  = 1'b1;
                par_out = a_xor;
                chk_ok  = a_xor;
            end
            DIR_B2A: begin
                chk_ok  = b_xor;
            end
            default: begin
                chk_ok  = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/ptx_flag_latch.sv
module ptx_flag_latch
    import ptx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic flag_en_n,
    input  logic flag_clr_n,
    input  logic chk_ok,
    output logic err_level
);

    flg_e     mode;
    flag_st_t st_d, st_q;
    logic     level;

    always_comb begin
        mode = flg_e'({~flag_en_n, ~flag_clr_n});
        unique case (mode)
            FLG_PASS:   level = chk_ok;
            FLG_SAMPLE: level = st_q.flag & chk_ok;
            FLG_CLEAR:  level = 1'b1;
            default:    level = st_q.flag;
        endcase
        st_d.flag = level;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{flag: 1'b1};
        else        st_q <= st_d;
    end

    assign err_level = level;

    // R6
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_en_n && flag_clr_n && !err_level) |=> (!(!flag_en_n && flag_clr_n) || !err_level));

    // R7
    clear_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_en_n && !flag_clr_n) |-> err_level);

    // R8
    store_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_en_n && flag_clr_n) |=> (!(flag_en_n && flag_clr_n) || $stable(err_level)));

endmodule

// File: rtl/parity_xcvr.sv
module parity_xcvr
    import ptx_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             oe_a_n,
    input  logic             oe_b_n,
    input  logic             flag_en_n,
    input  logic             flag_clr_n,
    input  logic [WIDTH-1:0] a_in,
    output logic [WIDTH-1:0] a_out,
    output logic             a_oe,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] b_out,
    output logic             b_oe,
    input  logic             par_in,
    output logic             par_out,
    output logic             par_oe,
    output logic             err_pull_low
);

    dir_e dir;
    logic chk_ok;
    logic err_level;

    ptx_dir_ctrl #(.WIDTH(WIDTH)) u_dir (
        .oe_a_n (oe_a_n),
        .oe_b_n (oe_b_n),
        .a_in   (a_in),
        .b_in   (b_in),
        .dir    (dir),
        .a_out  (a_out),
        .a_oe   (a_oe),
        .b_out  (b_out),
        .b_oe   (b_oe)
    );

    ptx_parity #(.WIDTH(WIDTH)) u_par (
        .dir     (dir),
        .a_in    (a_in),
        .b_in    (b_in),
        .par_in  (par_in),
        .par_out (par_out),
        .par_oe  (par_oe),
        .chk_ok  (chk_ok)
    );

    ptx_flag_latch u_flag (
        .clk        (clk),
        .rst_n      (rst_n),
        .flag_en_n  (flag_en_n),
        .flag_clr_n (flag_clr_n),
        .chk_ok     (chk_ok),
        .err_level  (err_level)
    );

    // Open-drain style: request a pull-down only when the flag reports an error
    assign err_pull_low = ~err_level;

    // R4
    released_all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_a_n && oe_b_n) |-> (!a_oe && !b_oe && !par_oe));

    // R1
    gen_odd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_a_n && !oe_b_n) |-> (par_oe && (^{a_in, par_out}) == 1'b1));

    // R10
    no_check_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_b_n == !oe_a_n && oe_a_n && !flag_en_n && !flag_clr_n) |-> !err_pull_low);

endmodule

// File: tb/parity_xcvr_tb.sv
module parity_xcvr_tb;

    localparam int CLK_PERIOD = 10;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         oe_a_n = 1'b1, oe_b_n = 1'b1;
    logic         flag_en_n = 1'b1, flag_clr_n = 1'b1;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic         par_in = 1'b0;
    logic [W-1:0] a_out, b_out;
    logic         a_oe, b_oe, par_out, par_oe, err_pull_low;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    parity_xcvr #(.WIDTH(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .oe_a_n(oe_a_n), .oe_b_n(oe_b_n),
        .flag_en_n(flag_en_n), .flag_clr_n(flag_clr_n),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
        .par_in(par_in), .par_out(par_out), .par_oe(par_oe),
        .err_pull_low(err_pull_low)
    );

    function automatic int ones(input logic [W:0] v);
        int n = 0;
        for (int i = 0; i <= W; i++) n += int'(v[i]);
        return n;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Apply inputs just after a falling edge, then settle
    task automatic apply(input logic oa, input logic ob, input logic en, input logic cl,
                         input logic [W-1:0] a, input logic [W-1:0] b, input logic p);
        @(negedge clk);
        oe_a_n = oa; oe_b_n = ob; flag_en_n = en; flag_clr_n = cl;
        a_in = a; b_in = b; par_in = p;
        #1;
    endtask

    task automatic clocks(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R11: store mode right after reset shows no error
        check(err_pull_low == 1'b0, "R11 reset flag", int'(err_pull_low), 0);

        // R4: released mode, several data values
        for (int v = 0; v < 4; v++) begin
            apply(1, 1, 0, 0, W'(v * 85), W'(v * 51), v[0]);
            check({a_oe, b_oe, par_oe} == 3'b000, "R4 released", int'({a_oe, b_oe, par_oe}), 0);
            check(err_pull_low == 1'b0, "R10 released no check", int'(err_pull_low), 0);
        end

        // R1 / R10: generate mode sweep
        for (int v = 0; v < 256; v++) begin
            apply(1, 0, 0, 0, W'(v), W'(255 - v), 1'b0);
            check(b_out == W'(v) && b_oe && !a_oe && par_oe && (ones({a_in, par_out}) % 2 == 1),
                  "R1 generate", int'({b_oe, a_oe, par_oe, par_out, b_out}),
                  int'({3'b101, ~(ones({1'b0, W'(v)}) % 2 == 1), W'(v)}));
            check(err_pull_low == 1'b0, "R10 generate no check", int'(err_pull_low), 0);
        end

        // R3 / R9: diagnostic mode sweep
        for (int v = 0; v < 256; v++) begin
            apply(0, 0, 0, 0, W'(v), W'(v ^ 170), 1'b1);
            check(b_out == W'(v) && b_oe && !a_oe && par_oe && (ones({a_in, par_out}) % 2 == 0),
                  "R3 diagnostic", int'({b_oe, a_oe, par_oe, par_out, b_out}),
                  int'({3'b101, (ones({1'b0, W'(v)}) % 2 == 1), W'(v)}));
            check(err_pull_low == (ones({1'b0, W'(v)}) % 2 == 0), "R9 diagnostic check",
                  int'(err_pull_low), int'(ones({1'b0, W'(v)}) % 2 == 0));
        end

        // R2 / R5: check mode sweep over B and the parity input
        for (int v = 0; v < 512; v++) begin
            apply(0, 1, 0, 0, W'(v * 7), W'(v), v[8]);
            check(a_out == W'(v) && a_oe && !b_oe && !par_oe, "R2 check dir",
                  int'({a_oe, b_oe, par_oe, a_out}), int'({3'b100, W'(v)}));
            check(err_pull_low == (ones({v[8], W'(v)}) % 2 == 0), "R5 pass",
                  int'(err_pull_low), int'(ones({v[8], W'(v)}) % 2 == 0));
        end

        // R7: clear, then store keeps no error
        apply(0, 1, 1, 0, 8'h00, 8'h00, 1'b0);
        check(err_pull_low == 1'b0, "R7 clear", int'(err_pull_low), 0);
        clocks(1);
        apply(0, 1, 1, 1, 8'h00, 8'h00, 1'b0);
        clocks(2);
        check(err_pull_low == 1'b0, "R7 after clear", int'(err_pull_low), 0);

        // R6: sample with passing data, then failing, then passing again
        apply(0, 1, 0, 1, 8'h01, 8'h01, 1'b0);
        check(err_pull_low == 1'b0, "R6 sample good", int'(err_pull_low), 0);
        apply(0, 1, 0, 1, 8'h00, 8'h03, 1'b0);
        check(err_pull_low == 1'b1, "R6 sample bad", int'(err_pull_low), 1);
        clocks(1);
        apply(0, 1, 0, 1, 8'h00, 8'h07, 1'b0);
        check(err_pull_low == 1'b1, "R6 sticky", int'(err_pull_low), 1);
        clocks(3);
        check(err_pull_low == 1'b1, "R6 sticky later", int'(err_pull_low), 1);

        // R8: store with either data keeps the asserted flag
        apply(0, 1, 1, 1, 8'h00, 8'h01, 1'b0);
        clocks(2);
        check(err_pull_low == 1'b1, "R8 store hold error", int'(err_pull_low), 1);

        // R7 then R8: clear, store with failing data stays released
        apply(0, 1, 1, 0, 8'h00, 8'h00, 1'b0);
        clocks(1);
        apply(0, 1, 1, 1, 8'h00, 8'h00, 1'b0);
        clocks(3);
        check(err_pull_low == 1'b0, "R8 store ignores bad data", int'(err_pull_low), 0);

        // R5: pass value survives into store
        apply(0, 1, 0, 0, 8'h00, 8'h0F, 1'b0);
        check(err_pull_low == 1'b1, "R5 pass bad", int'(err_pull_low), 1);
        clocks(1);
        apply(0, 1, 1, 1, 8'h00, 8'h0F, 1'b1);
        clocks(2);
        check(err_pull_low == 1'b1, "R5 pass retained", int'(err_pull_low), 1);

        // R9: sample in diagnostic mode captures an even A word
        apply(0, 1, 1, 0, 8'h00, 8'h00, 1'b0);
        clocks(1);
        apply(0, 0, 0, 1, 8'h03, 8'h00, 1'b0);
        check(err_pull_low == 1'b1, "R9 diagnostic sample", int'(err_pull_low), 1);
        clocks(1);
        apply(0, 0, 0, 1, 8'h01, 8'h00, 1'b0);
        check(err_pull_low == 1'b1, "R9 diagnostic sticky", int'(err_pull_low), 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule